// File: doc/BRIEF.md
# Configurable Logic Element Cluster

This block is a group of ten configurable logic elements running in normal (non-arithmetic) mode. Each element holds a 4-input lookup table whose behaviour is a 16-bit truth-table mask, and one output register. A configuration bit can swap the first table input for the lookup result of the previous element, which cascades the tables. Another bit can swap the third input for a carry bit rippled from the previous element. The registers of all ten elements share one set of clock, enable and clear/load controls. A per-element source select decides what each register captures: the element's own table result, the previous element's register (a shift chain), or the fourth data input directly. The last choice lets one element carry an unrelated register next to its combinational table.

Configuration is written one element at a time through a plain parallel write port. Element 0 takes its three chain inputs from cluster pins, and the chain outputs of element 9 leave the cluster on their own pins. The configuration port is a single-beat write strobe with no back-pressure: a word is taken on every clock edge where `cfg_we` is high, and nothing ever stalls. The data and control pins are plain levels.

Top module: `lec_cluster`

## Requirements
- R1: With both swap bits clear, `comb_out[i]` equals mask bit `{din_d[i], din_c[i], din_b[i], din_a[i]}`, where `din_a` is index bit 0 and `din_d` is index bit 3. The mask is `cfg_data[15:0]`.
- R2: When config bit 16 is set, index bit 2 comes from the carry into element i instead of `din_c[i]`. The carry into element 0 is `carry_in`. Each element passes on `(a&b)|(cin&(a|b))` of its `din_a`, `din_b` and carry in, and element 9's result appears on `carry_out`.
- R3: When config bit 17 is set, index bit 0 is the table output of element i-1 instead of `din_a[i]`. For element 0 it is `lut_chain_in`. `lut_chain_out` equals `comb_out[9]`.
- R4: A register source select (config bits 19:18) of 1 makes element i capture the register of element i-1 (`reg_chain_in` for element 0). `reg_chain_out` equals `reg_out[9]`, so ten enabled edges shift a bit from `reg_chain_in` to `reg_chain_out`.
- R5: A source select of 2 (packed) makes the register capture `din_d[i]`, while `comb_out[i]` still shows the table result.
- R6: A source select of 0 or 3 makes the register capture the element's own table result.
- R7: `aclr` high clears every register at once, without a clock edge, and overrides all other controls.
- R8: A rising `aload` (with `aclr` low) loads every register with its `din_c` bit at once. Each clock edge while `aload` stays high reloads `din_c`.
- R9: With `aclr` and `aload` low, an edge with `sclr` high clears the registers. Otherwise an edge with `sload` high loads `din_c`. Both act whatever the level of `ena`.
- R10: With no clear or load active, an edge with `ena` low leaves every register unchanged, and an edge with `ena` high captures the selected source.
- R11: An edge with `cfg_we` high writes `cfg_data` into element `cfg_addr` when the address is below 10. Addresses 10 to 15 change no configuration.
- R12: `rst_n` low clears all configuration at once, so every mask reads zero and every `comb_out` bit is 0. It does not touch the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and configuration store |
| rst_n | input | 1 | Active-low asynchronous configuration reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Element index to write |
| cfg_data | input | 20 | Mask [15:0], carry swap [16], chain swap [17], register source [19:18] |
| din_a | input | 10 | First data input, one bit per element |
| din_b | input | 10 | Second data input, one bit per element |
| din_c | input | 10 | Third data input, also the load value |
| din_d | input | 10 | Fourth data input, also the packed register input |
| ena | input | 1 | Shared clock enable for capture |
| aclr | input | 1 | Shared asynchronous clear |
| aload | input | 1 | Shared asynchronous load |
| sclr | input | 1 | Shared synchronous clear |
| sload | input | 1 | Shared synchronous load |
| carry_in | input | 1 | Carry into element 0 |
| lut_chain_in | input | 1 | Table chain into element 0 |
| reg_chain_in | input | 1 | Register chain into element 0 |
| comb_out | output | 10 | Combinational table results |
| reg_out | output | 10 | Register outputs |
| carry_out | output | 1 | Carry out of element 9 |
| lut_chain_out | output | 1 | Table chain out of element 9 |
| reg_chain_out | output | 1 | Register chain out of element 9 |

## Verification
The tables are first tried with random masks and free random data. Each output bit is then an independent mask lookup, which shows up a wrong index bit order. Runs with every element set to chain or carry swap tell a correct ripple from one that takes the wrong neighbour or the local input. Runs with all elements in packed mode or shift mode tell the register source select apart from the table path. A ten-step shift of a known pattern shows the chain order end to end. Control patterns that hold several of `aclr`, `aload`, `sclr`, `sload` and `ena` at once show whether their priority order is right.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int LUT_K  = 4;
  localparam int MASK_W = 1 << LUT_K;

  typedef enum logic [1:0] {
    DS_LUT     = 2'd0,
    DS_CHAIN   = 2'd1,
    DS_DIRECT  = 2'd2,
    DS_LUT_ALT = 2'd3
  } dsrc_e;

  // MSB first: dsrc [19:18], chain_sel [17], carry_sel [16], mask [15:0]
  typedef struct packed {
    dsrc_e              dsrc;
    logic               chain_sel;
    logic               carry_sel;
    logic [MASK_W-1:0]  mask;
  } le_cfg_t;

  localparam int CFG_W = $bits(le_cfg_t);
endpackage

// File: rtl/lec_lut.sv
module lec_lut #(
  parameter int K = 4,
  localparam int M = 1 << K
) (
  input  logic [M-1:0] mask,
  input  logic [K-1:0] sel,
  output logic         y
);
  // binary mux tree, one stage per select bit
  logic [M-1:0] stage [K+1];

  assign stage[0] = mask;

  for (genvar lv = 0; lv < K; lv++) begin : g_lvl
    localparam int W = M >> (lv + 1);
    for (genvar n = 0; n < W; n++) begin : g_node
      assign stage[lv+1][n] = sel[lv] ? stage[lv][2*n+1] : stage[lv][2*n];
    end
    if (W < M) begin : g_pad
      assign stage[lv+1][M-1:W] = '0;
    end
  end

  assign y = stage[K][0];
endmodule

// File: rtl/lec_reg.sv
module lec_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ena,
  input  logic aclr,
  input  logic aload,
  input  logic sclr,
  input  logic sload,
  input  logic d_cap,
  input  logic d_ld,
  output logic q
);
  always_ff @(posedge clk or posedge aclr or posedge aload) begin
    if (aclr)       q <= 1'b0;
    else if (aload) q <= d_ld;
    else if (sclr)  q <= 1'b0;
    else if (sload) q <= d_ld;
    else if (ena)   q <= d_cap;
  end

  AST_ACLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) aclr |-> !q); // R7
  AST_ALOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n || aclr) (aload && $past(aload) && !$past(aclr)) |-> q == $past(d_ld)); // R8
  AST_SCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n || aclr || aload) sclr |=> !q); // R9
  AST_SLOAD_TAKE: assert property (@(posedge clk) disable iff (!rst_n || aclr || aload) (sload && !sclr) |=> q == $past(d_ld)); // R9
  AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n || aclr || aload) (!ena && !sclr && !sload) |=> $stable(q)); // R10
endmodule

// File: rtl/lec_element.sv
module lec_element
  import lec_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  le_cfg_t cfg,
  input  logic    d_a,
  input  logic    d_b,
  input  logic    d_c,
  input  logic    d_d,
  input  logic    cin,
  input  logic    lut_in,
  input  logic    reg_in,
  input  logic    ena,
  input  logic    aclr,
  input  logic    aload,
  input  logic    sclr,
  input  logic    sload,
  output logic    comb,
  output logic    cout,
  output logic    q
);
  logic [LUT_K-1:0] idx;
  logic             d_cap;

  assign idx[0] = cfg.chain_sel ? lut_in : d_a;
  assign idx[1] = d_b;
  assign idx[2] = cfg.carry_sel ? cin : d_c;
  assign idx[3] = d_d;

  assign cout = (d_a & d_b) | (cin & (d_a | d_b));

  lec_lut #(.K(LUT_K)) lut_i (
    .mask (cfg.mask),
    .sel  (idx),
    .y    (comb)
  );

  always_comb begin
    unique case (cfg.dsrc)
      DS_CHAIN:  d_cap = reg_in;
      DS_DIRECT: d_cap = d_d;
      default:   d_cap = comb;
    endcase
  end

  lec_reg reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ena   (ena),
    .aclr  (aclr),
    .aload (aload),
    .sclr  (sclr),
    .sload (sload),
    .d_cap (d_cap),
    .d_ld  (d_c),
    .q     (q)
  );

  AST_PACKED_DIRECT: assert property (@(posedge clk) disable iff (!rst_n || aclr || aload) (ena && !sclr && !sload && cfg.dsrc == DS_DIRECT) |=> q == $past(d_d)); // R5
  AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n || aclr || aload) (ena && !sclr && !sload && cfg.dsrc == DS_CHAIN) |=> q == $past(reg_in)); // R4
endmodule

// File: rtl/lec_cluster.sv
module lec_cluster
  import lec_pkg::*;
#(
  parameter int N_ELEM = 10,
  parameter int ADDR_W = $clog2(N_ELEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic [N_ELEM-1:0] din_a,
  input  logic [N_ELEM-1:0] din_b,
  input  logic [N_ELEM-1:0] din_c,
  input  logic [N_ELEM-1:0] din_d,
  input  logic              ena,
  input  logic              aclr,
  input  logic              aload,
  input  logic              sclr,
  input  logic              sload,
  input  logic              carry_in,
  input  logic              lut_chain_in,
  input  logic              reg_chain_in,
  output logic [N_ELEM-1:0] comb_out,
  output logic [N_ELEM-1:0] reg_out,
  output logic              carry_out,
  output logic              lut_chain_out,
  output logic              reg_chain_out
);
  le_cfg_t [N_ELEM-1:0] cfg_q;
  logic                 addr_ok;

  assign addr_ok = int'(cfg_addr) < N_ELEM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg_q <= '0;
    else if (cfg_we && addr_ok) cfg_q[cfg_addr] <= le_cfg_t'(cfg_data);
  end

  logic lut_c [N_ELEM+1];
  logic car_c [N_ELEM+1];
  logic reg_c [N_ELEM+1];

  assign lut_c[0] = lut_chain_in;
  assign car_c[0] = carry_in;
  assign reg_c[0] = reg_chain_in;

  for (genvar i = 0; i < N_ELEM; i++) begin : g_le
    lec_element le_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg    (cfg_q[i]),
      .d_a    (din_a[i]),
      .d_b    (din_b[i]),
      .d_c    (din_c[i]),
      .d_d    (din_d[i]),
      .cin    (car_c[i]),
      .lut_in (lut_c[i]),
      .reg_in (reg_c[i]),
      .ena    (ena),
      .aclr   (aclr),
      .aload  (aload),
      .sclr   (sclr),
      .sload  (sload),
      .comb   (lut_c[i+1]),
      .cout   (car_c[i+1]),
      .q      (reg_c[i+1])
    );
    assign comb_out[i] = lut_c[i+1];
    assign reg_out[i]  = reg_c[i+1];
  end

  assign carry_out     = car_c[N_ELEM];
  assign lut_chain_out = lut_c[N_ELEM];
  assign reg_chain_out = reg_c[N_ELEM];

  AST_CFG_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && addr_ok) |=> cfg_q[$past(cfg_addr)] == $past(cfg_data)); // R11
  AST_CFG_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && !addr_ok) |=> $stable(cfg_q)); // R11
  AST_RST_CLEARS: assert property (@(posedge clk) !rst_n |-> cfg_q == '0 && comb_out == '0); // R12
endmodule

// File: tb/lec_cluster_tb_top.sv
module lec_cluster_tb_top;
  import lec_pkg::*;
  localparam int N = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_we, ena, aclr, aload, sclr, sload;
  logic carry_in, lut_chain_in, reg_chain_in;
  logic [3:0] cfg_addr;
  logic [CFG_W-1:0] cfg_data;
  logic [N-1:0] din_a, din_b, din_c, din_d;
  logic [N-1:0] comb_out, reg_out;
  logic carry_out, lut_chain_out, reg_chain_out;

  lec_cluster dut_i (.*);

  int checks = 0, errors = 0;
  logic [CFG_W-1:0] m_cfg [N];
  logic m_q [N];
  logic m_lut [N];
  string m_tag [N];
  logic m_carry, m_lchain;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_comb();
    logic pl = lut_chain_in;
    logic c  = carry_in;
    for (int i = 0; i < N; i++) begin
      logic a0 = m_cfg[i][17] ? pl : din_a[i];
      logic a2 = m_cfg[i][16] ? c : din_c[i];
      logic [3:0] ix = {din_d[i], a2, din_b[i], a0};
      m_lut[i] = m_cfg[i][ix];
      c  = (din_a[i] & din_b[i]) | (c & (din_a[i] | din_b[i]));
      pl = m_lut[i];
    end
    m_carry  = c;
    m_lchain = pl;
  endfunction

  function automatic void model_edge();
    logic old [N];
    old = m_q;
    for (int i = 0; i < N; i++) begin
      if (aclr)       begin m_q[i] = 1'b0;     m_tag[i] = "R7"; end
      else if (aload) begin m_q[i] = din_c[i]; m_tag[i] = "R8"; end
      else if (sclr)  begin m_q[i] = 1'b0;     m_tag[i] = "R9"; end
      else if (sload) begin m_q[i] = din_c[i]; m_tag[i] = "R9"; end
      else if (!ena)  m_tag[i] = "R10";
      else begin
        case (m_cfg[i][19:18])
          2'd1: begin m_q[i] = (i == 0) ? reg_chain_in : old[i-1]; m_tag[i] = "R4"; end
          2'd2: begin m_q[i] = din_d[i]; m_tag[i] = "R5"; end
          default: begin m_q[i] = m_lut[i]; m_tag[i] = "R6"; end
        endcase
      end
    end
    if (cfg_we && cfg_addr < 4'(N)) m_cfg[cfg_addr] = cfg_data;
  endfunction

  task automatic check_comb();
    model_comb();
    for (int i = 0; i < N; i++)
      chk(m_cfg[i][17] ? "R3" : (m_cfg[i][16] ? "R2" : "R1"), $sformatf("comb_out[%0d]", i),
          32'(comb_out[i]), 32'(m_lut[i]));
    chk("R2", "carry_out", 32'(carry_out), 32'(m_carry));
    chk("R3", "lut_chain_out", 32'(lut_chain_out), 32'(m_lchain));
  endtask

  task automatic check_reg();
    for (int i = 0; i < N; i++)
      chk(m_tag[i], $sformatf("reg_out[%0d]", i), 32'(reg_out[i]), 32'(m_q[i]));
    chk("R4", "reg_chain_out", 32'(reg_chain_out), 32'(m_q[N-1]));
  endtask

  // called at a falling edge with inputs already driven
  task automatic step();
    #1 check_comb();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_reg();
  endtask

  task automatic rand_data();
    din_a = N'($urandom); din_b = N'($urandom);
    din_c = N'($urandom); din_d = N'($urandom);
    carry_in = 1'($urandom); lut_chain_in = 1'($urandom); reg_chain_in = 1'($urandom);
  endtask

  task automatic rand_ctl();
    ena   = ($urandom % 4) != 0;
    sclr  = ($urandom % 8) == 0;
    sload = ($urandom % 8) == 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [CFG_W-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    rand_data();
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    rst_n = 1'b0; aclr = 1'b1; aload = 1'b0; sclr = 1'b0; sload = 1'b0; ena = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    rand_data();
    for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_q[i] = 1'b0; m_tag[i] = "R7"; end
    repeat (3) @(negedge clk);
    #1;
    chk("R12", "comb_out in reset", 32'(comb_out), 32'(0));
    chk("R7", "reg_out under aclr", 32'(reg_out), 32'(0));
    @(negedge clk);
    rst_n = 1'b1; aclr = 1'b0;

    // random masks and modes, random controls
    for (int i = 0; i < N; i++) wr(4'(i), CFG_W'($urandom));
    for (int k = 0; k < 300; k++) begin rand_data(); rand_ctl(); step(); end

    // writes to unused addresses leave configuration alone
    ena = 1'b0; sclr = 1'b0; sload = 1'b0;
    for (int a = N; a < 16; a++) wr(4'(a), CFG_W'($urandom));
    #1 model_comb();
    for (int i = 0; i < N; i++)
      chk("R11", $sformatf("comb_out[%0d] after ignored write", i), 32'(comb_out[i]), 32'(m_lut[i]));
    @(negedge clk);

    // packed mode everywhere
    for (int i = 0; i < N; i++) wr(4'(i), {2'd2, 2'($urandom), 16'($urandom)});
    for (int k = 0; k < 60; k++) begin rand_data(); rand_ctl(); step(); end

    // cascaded tables with carry swap
    for (int i = 0; i < N; i++) wr(4'(i), {2'($urandom), 2'b11, 16'($urandom)});
    for (int k = 0; k < 100; k++) begin rand_data(); rand_ctl(); step(); end

    // ten-stage shift through the register chain
    for (int i = 0; i < N; i++) wr(4'(i), {2'd1, 18'($urandom)});
    pat = N'($urandom) | 10'b1000000001;
    ena = 1'b1; sclr = 1'b0; sload = 1'b0;
    for (int k = 0; k < N; k++) begin
      rand_data(); reg_chain_in = pat[k]; step();
    end
    for (int i = 0; i < N; i++)
      chk("R4", $sformatf("shift stage %0d", i), 32'(reg_out[i]), 32'(pat[N-1-i]));

    // control priority corners
    ena = 1'b1; sclr = 1'b1; sload = 1'b1; rand_data(); step();        // sclr over sload
    sclr = 1'b0; sload = 1'b1; ena = 1'b0; rand_data(); step();        // sload with ena low
    sload = 1'b0; ena = 1'b0; rand_data(); step();                     // hold
    rand_data(); aload = 1'b1; m_q = '{default: 1'b0};
    #1; for (int i = 0; i < N; i++) m_q[i] = din_c[i];
    chk("R8", "async load value", 32'(reg_out), 32'(din_c));
    sclr = 1'b1; ena = 1'b1; step();                                   // aload over sclr
    aclr = 1'b1; #1;
    for (int i = 0; i < N; i++) m_q[i] = 1'b0;
    chk("R7", "async clear over load", 32'(reg_out), 32'(0));
    step();
    aclr = 1'b0; aload = 1'b0; sclr = 1'b0;
    for (int k = 0; k < 40; k++) begin rand_data(); rand_ctl(); step(); end

    // configuration reset mid-run
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) m_cfg[i] = '0;
    #1;
    chk("R12", "comb_out after rst_n", 32'(comb_out), 32'(0));
    ena = 1'b0; rand_data(); step();
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) begin rand_data(); rand_ctl(); step(); end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule